// File: doc/BRIEF.md
# Coprocessor Trap Entry and Return Sequencer

This block is the multi-cycle control unit a small 32-bit core uses to enter a coprocessor trap and to return from a trap handler. When a coprocessor instruction issues while no coprocessor is fitted, or while a coprocessor fault is still recorded from earlier work, the sequencer pushes the status word and then the faulting instruction's address onto the system stack. It then lowers the system stack pointer by two words, clears the stack-select flag in the status word and sends the program counter to a fixed offset above the trap table base.

Coprocessor faults do not trap when they happen. A pulse on the fault input sets a sticky flag, and the trap is taken only when the next coprocessor instruction issues. The return request reverses the entry sequence through the general stack register: it reads the program counter from the word that register points at, then reads the status word from the next word, and moves the register up by two words. A return issued while the stack-select flag is set is refused and reported as a one-cycle usage error.

All memory traffic goes through one single-port bus with a ready handshake. The core writes the register results when it sees the write strobes, which are valid during the one-cycle `done`.

Top module: `coproc_trap_seq`

## Requirements
- R1: A coprocessor instruction (`copInstr`) issued with `copPresent` low starts trap entry, and the new PC is TBR + 0x3E0.
- R2: A `copErrIn` pulse sets a sticky fault flag and causes no activity by itself. The next `copInstr` with `copPresent` high takes a trap whose new PC is TBR + 0x3DC, and this clears the flag, so a later `copInstr` has no effect.
- R3: When the fault flag is set and `copPresent` is low, the absent-coprocessor trap (0x3E0) is taken and the fault flag stays set for a later instruction.
- R4: Trap entry makes exactly two writes in this order: first the input PS to address SSP-4, then `instrAddr` to address SSP-8.
- R5: At the end of trap entry, `sspOut` = SSP-8 and `psOut` equals the input PS with bit 5 (the stack-select flag) cleared and every other bit unchanged. `pcWe`, `psWe` and `sspWe` are high and `r15We` is low.
- R6: A return request with PS bit 5 clear reads PC from address R15, then reads PS from R15+4. It ends with `pcOut` and `psOut` equal to those two words, `r15Out` = R15+8, `pcWe`, `psWe` and `r15We` high, and `sspWe` low.
- R7: A return request with PS bit 5 set raises `usageErr` for exactly one cycle, in the cycle after the request. It makes no memory access and does not set `busy` or `done`.
- R8: While `memReq` is high and `memReady` is low, `memAddr`, `memWdata` and `memWe` stay unchanged. Each access completes in the cycle in which `memReady` is high.
- R9: After reset `busy`, `done`, `memReq` and `usageErr` are low. `done` lasts one cycle and arrives 3 cycles after the request edge, plus one cycle for each cycle of `memReady` stall.
- R10: Requests that arrive while `busy` is high are ignored. A `copInstr` with `copPresent` high and no fault recorded starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| copInstr | input | 1 | Coprocessor instruction is issuing (one-cycle pulse) |
| copPresent | input | 1 | A coprocessor is fitted |
| copErrIn | input | 1 | Coprocessor fault event (one-cycle pulse) |
| retiReq | input | 1 | Return-from-trap request (one-cycle pulse) |
| instrAddr | input | 32 | Address of the issuing instruction |
| psIn | input | 32 | Current program status word |
| sspIn | input | 32 | Current system stack pointer |
| r15In | input | 32 | Current general stack register |
| tbrIn | input | 32 | Trap table base |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 32 | Byte address of the access |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid while memReady is high |
| memReady | input | 1 | Access completes this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finishes this cycle |
| usageErr | output | 1 | Return refused because stack-select is set |
| pcWe | output | 1 | Write pcOut to PC |
| pcOut | output | 32 | New PC |
| psWe | output | 1 | Write psOut to PS |
| psOut | output | 32 | New status word |
| sspWe | output | 1 | Write sspOut to SSP |
| sspOut | output | 32 | New system stack pointer |
| r15We | output | 1 | Write r15Out to R15 |
| r15Out | output | 32 | New general stack register |

## Verification
A request is sampled at one clock edge. The first memory access is presented in the next cycle, and with no stalls `done` and the register write strobes are high in the third cycle after that edge. Each stall cycle on either of the two accesses delays this by one cycle. The bench drives each request on a falling edge and counts falling edges until `done`. It compares that count with 3 plus twice the configured stall length, and it reads the result ports in that same `done` cycle. A refused return is checked on the first falling edge after its request, and again one cycle later to confirm that the pulse has ended.

// File: rtl/ctseq_pkg.sv
package ctseq_pkg;

  typedef enum logic [1:0] {
    PH_PUSH_PS,
    PH_PUSH_PC,
    PH_POP_PC,
    PH_POP_PS
  } memPhase_e;

  typedef struct packed {
    logic      capTrap;
    logic      capRet;
    logic      vecErr;
    logic      grabPc;
    logic      grabPs;
    logic      retMode;
    memPhase_e phase;
  } ctrlStrobe_t;

endpackage

// File: rtl/ctseq_ctrl.sv
module ctseq_ctrl
  import ctseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        copInstr,
  input  logic        copPresent,
  input  logic        copErrIn,
  input  logic        retiReq,
  input  logic        psSFlag,
  input  logic        memReady,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        memWe,
  output logic        busy,
  output logic        done,
  output logic        pcWe,
  output logic        psWe,
  output logic        sspWe,
  output logic        r15We,
  output logic        usageErr
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PS,
    ST_PUSH_PC,
    ST_POP_PC,
    ST_POP_PS,
    ST_END_TRAP,
    ST_END_RET
  } state_e;

  state_e state, stateNext;
  logic   errLatch;
  logic   idle, startAbsent, startErr, startRet, badRet;

  assign idle        = (state == ST_IDLE);
  assign startAbsent = idle && copInstr && !copPresent;
  assign startErr    = idle && copInstr && copPresent && errLatch;
  assign startRet    = idle && retiReq && !copInstr && !psSFlag;
  assign badRet      = idle && retiReq && !copInstr && psSFlag;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (startAbsent || startErr) stateNext = ST_PUSH_PS;
        else if (startRet)           stateNext = ST_POP_PC;
      end
      ST_PUSH_PS:  if (memReady) stateNext = ST_PUSH_PC;
      ST_PUSH_PC:  if (memReady) stateNext = ST_END_TRAP;
      ST_POP_PC:   if (memReady) stateNext = ST_POP_PS;
      ST_POP_PS:   if (memReady) stateNext = ST_END_RET;
      ST_END_TRAP: stateNext = ST_IDLE;
      ST_END_RET:  stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      errLatch <= 1'b0;
      usageErr <= 1'b0;
    end else begin
      state    <= stateNext;
      usageErr <= badRet;
      if (copErrIn)      errLatch <= 1'b1;
      else if (startErr) errLatch <= 1'b0;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.capTrap = startAbsent || startErr;
    strobe.vecErr  = startErr && !startAbsent;
    strobe.capRet  = startRet;
    strobe.grabPc  = (state == ST_POP_PC) && memReady;
    strobe.grabPs  = (state == ST_POP_PS) && memReady;
    strobe.retMode = (state == ST_END_RET);
    unique case (state)
      ST_PUSH_PC: strobe.phase = PH_PUSH_PC;
      ST_POP_PC:  strobe.phase = PH_POP_PC;
      ST_POP_PS:  strobe.phase = PH_POP_PS;
      default:    strobe.phase = PH_PUSH_PS;
    endcase
  end

  assign memReq = (state == ST_PUSH_PS) || (state == ST_PUSH_PC) ||
                  (state == ST_POP_PC)  || (state == ST_POP_PS);
  assign memWe  = (state == ST_PUSH_PS) || (state == ST_PUSH_PC);
  assign busy   = !idle;
  assign done   = (state == ST_END_TRAP) || (state == ST_END_RET);
  assign pcWe   = done;
  assign psWe   = done;
  assign sspWe  = (state == ST_END_TRAP);
  assign r15We  = (state == ST_END_RET);

  // R2: a recorded fault survives until its own trap is taken
  a_r2_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    errLatch && !startErr |=> errLatch);

  // R9: done is a single-cycle pulse
  a_r9_done_once: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: absent trap wins over a recorded fault
  a_r3_absent_first: assert property (@(posedge clk) disable iff (!rstN)
    startAbsent |=> errLatch || $past(errLatch) == 1'b0);

endmodule

// File: rtl/ctseq_dpath.sv
module ctseq_dpath
  import ctseq_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          S_BIT      = 5,
  parameter int unsigned VEC_ABSENT = 32'h3E0,
  parameter int unsigned VEC_ERROR  = 32'h3DC
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic [XLEN-1:0] instrAddr,
  input  logic [XLEN-1:0] psIn,
  input  logic [XLEN-1:0] sspIn,
  input  logic [XLEN-1:0] r15In,
  input  logic [XLEN-1:0] tbrIn,
  input  logic [XLEN-1:0] memRdata,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] psOut,
  output logic [XLEN-1:0] sspOut,
  output logic [XLEN-1:0] r15Out
);

  localparam logic [XLEN-1:0] STEP       = XLEN'(XLEN / 8);
  localparam logic [XLEN-1:0] FRAME      = XLEN'(2 * (XLEN / 8));
  localparam logic [XLEN-1:0] S_MASK     = XLEN'(1) << S_BIT;
  localparam logic [XLEN-1:0] OFS_ABSENT = XLEN'(VEC_ABSENT);
  localparam logic [XLEN-1:0] OFS_ERROR  = XLEN'(VEC_ERROR);

  logic [XLEN-1:0] baseReg, psSave, pcSave, tbrSave, vecReg, popPc, popPs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      psSave  <= '0;
      pcSave  <= '0;
      tbrSave <= '0;
      vecReg  <= '0;
      popPc   <= '0;
      popPs   <= '0;
    end else begin
      if (strobe.capTrap) begin
        baseReg <= sspIn;
        psSave  <= psIn;
        pcSave  <= instrAddr;
        tbrSave <= tbrIn;
        vecReg  <= strobe.vecErr ? OFS_ERROR : OFS_ABSENT;
      end else if (strobe.capRet) begin
        baseReg <= r15In;
      end
      if (strobe.grabPc) popPc <= memRdata;
      if (strobe.grabPs) popPs <= memRdata;
    end
  end

  always_comb begin
    unique case (strobe.phase)
      PH_PUSH_PS: memAddr = baseReg - STEP;
      PH_PUSH_PC: memAddr = baseReg - FRAME;
      PH_POP_PC:  memAddr = baseReg;
      PH_POP_PS:  memAddr = baseReg + STEP;
      default:    memAddr = baseReg;
    endcase
  end

  assign memWdata = (strobe.phase == PH_PUSH_PC) ? pcSave : psSave;
  assign pcOut    = strobe.retMode ? popPc : tbrSave + vecReg;
  assign psOut    = strobe.retMode ? popPs : (psSave & ~S_MASK);
  assign sspOut   = baseReg - FRAME;
  assign r15Out   = baseReg + FRAME;

  // R10: entry and return never start in the same cycle
  a_r10_one_capture: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.capTrap && strobe.capRet));

  // R6: status pop follows the PC pop
  a_r6_pop_order: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grabPc |=> !strobe.grabPc);

endmodule

// File: rtl/coproc_trap_seq.sv
module coproc_trap_seq
  import ctseq_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          S_BIT      = 5,
  parameter int unsigned VEC_ABSENT = 32'h3E0,
  parameter int unsigned VEC_ERROR  = 32'h3DC
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            copInstr,
  input  logic            copPresent,
  input  logic            copErrIn,
  input  logic            retiReq,
  input  logic [XLEN-1:0] instrAddr,
  input  logic [XLEN-1:0] psIn,
  input  logic [XLEN-1:0] sspIn,
  input  logic [XLEN-1:0] r15In,
  input  logic [XLEN-1:0] tbrIn,
  output logic            memReq,
  output logic            memWe,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  input  logic [XLEN-1:0] memRdata,
  input  logic            memReady,
  output logic            busy,
  output logic            done,
  output logic            usageErr,
  output logic            pcWe,
  output logic [XLEN-1:0] pcOut,
  output logic            psWe,
  output logic [XLEN-1:0] psOut,
  output logic            sspWe,
  output logic [XLEN-1:0] sspOut,
  output logic            r15We,
  output logic [XLEN-1:0] r15Out
);

  ctrlStrobe_t strobe;

  ctseq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .copInstr(copInstr), .copPresent(copPresent), .copErrIn(copErrIn),
    .retiReq(retiReq), .psSFlag(psIn[S_BIT]), .memReady(memReady),
    .strobe(strobe), .memReq(memReq), .memWe(memWe),
    .busy(busy), .done(done),
    .pcWe(pcWe), .psWe(psWe), .sspWe(sspWe), .r15We(r15We),
    .usageErr(usageErr)
  );

  ctseq_dpath #(
    .XLEN(XLEN), .S_BIT(S_BIT),
    .VEC_ABSENT(VEC_ABSENT), .VEC_ERROR(VEC_ERROR)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .instrAddr(instrAddr), .psIn(psIn), .sspIn(sspIn), .r15In(r15In),
    .tbrIn(tbrIn), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .pcOut(pcOut), .psOut(psOut), .sspOut(sspOut), .r15Out(r15Out)
  );

  // R8: a stalled access keeps its address, data and direction
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWdata) && $stable(memWe));

  // R7: a refused return touches no memory and starts no sequence
  a_r7_no_access: assert property (@(posedge clk) disable iff (!rstN)
    usageErr |-> !busy && !memReq);

  // R10: a request seen while busy cannot produce a usage error
  a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !usageErr);

  // R5: only a trap moves SSP, only a return moves R15
  a_r5_stack_sel: assert property (@(posedge clk) disable iff (!rstN)
    !(sspWe && r15We));

endmodule

// File: tb/coproc_trap_seq_tb_top.sv
`timescale 1ns/1ps
module coproc_trap_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        copInstr = 1'b0, copPresent = 1'b1, copErrIn = 1'b0, retiReq = 1'b0;
  logic [31:0] instrAddr = '0, psIn = '0, sspIn = '0, r15In = '0, tbrIn = '0;
  logic        memReq, memWe, memReady = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        busy, done, usageErr, pcWe, psWe, sspWe, r15We;
  logic [31:0] pcOut, psOut, sspOut, r15Out;

  always #2 clk = ~clk;

  coproc_trap_seq dut_i (
    .clk(clk), .rstN(rstN), .copInstr(copInstr), .copPresent(copPresent),
    .copErrIn(copErrIn), .retiReq(retiReq), .instrAddr(instrAddr), .psIn(psIn),
    .sspIn(sspIn), .r15In(r15In), .tbrIn(tbrIn), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .busy(busy), .done(done), .usageErr(usageErr), .pcWe(pcWe), .pcOut(pcOut),
    .psWe(psWe), .psOut(psOut), .sspWe(sspWe), .sspOut(sspOut), .r15We(r15We),
    .r15Out(r15Out)
  );

  int checks = 0, fails = 0;
  int memWait = 0, waitCnt = 0;
  int wrCnt = 0, opCnt = 0, cycles = 0;
  logic [31:0] mem [256];
  logic [31:0] wrAddr [16];
  logic [31:0] wrData [16];

  assign memRdata = mem[memAddr[9:2]];

  // memory model: ready after memWait stall cycles per access
  always @(negedge clk) begin
    if (!memReq) begin
      memReady = 1'b0; waitCnt = 0;
    end else if (memReady) begin
      if (memWait == 0) memReady = 1'b1;
      else begin memReady = 1'b0; waitCnt = 1; end
    end else if (waitCnt >= memWait) memReady = 1'b1;
    else waitCnt++;
  end

  always @(posedge clk) begin
    cycles++;
    if (memReq && memReady) begin
      opCnt++;
      if (memWe) begin
        mem[memAddr[9:2]] = memWdata;
        wrAddr[wrCnt % 16] = memAddr;
        wrData[wrCnt % 16] = memWdata;
        wrCnt++;
      end
    end
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulseReq(input bit cop, input bit reti);
    @(negedge clk);
    copInstr = cop; retiReq = reti;
    @(negedge clk);
    copInstr = 1'b0; retiReq = 1'b0;
  endtask

  task automatic waitDone(output int n);
    n = 1;
    while (!done && n < 60) begin @(negedge clk); n++; end
  endtask

  // trap entry scenario: covers R1/R2/R3 vector choice, R4 pushes, R5 results, R9 timing
  task automatic trapCase(input string tag, input bit present, input int w,
                          input logic [31:0] ps, input logic [31:0] vec);
    int n, w0;
    memWait = w; copPresent = present;
    sspIn = 32'h200; psIn = ps; tbrIn = 32'h1000; instrAddr = 32'h0000_4A6C;
    w0 = wrCnt;
    pulseReq(1'b1, 1'b0);
    waitDone(n);
    check(n == 3 + 2 * w, {tag, " R9 done cycle"}, n, 3 + 2 * w);
    check(pcWe && pcOut == 32'h1000 + vec, {tag, " new PC"}, pcOut, 32'h1000 + vec);
    check(sspWe && !r15We && sspOut == 32'h1F8, {tag, " R5 ssp"}, sspOut, 32'h1F8);
    check(psWe && psOut == (ps & ~32'h20), {tag, " R5 ps"}, psOut, ps & ~32'h20);
    check(wrCnt - w0 == 2, {tag, " R4 write count"}, wrCnt - w0, 2);
    check(wrAddr[w0 % 16] == 32'h1FC && wrData[w0 % 16] == ps, {tag, " R4 first push"},
          wrData[w0 % 16], ps);
    check(wrAddr[(w0 + 1) % 16] == 32'h1F8 && wrData[(w0 + 1) % 16] == 32'h4A6C,
          {tag, " R4 second push"}, wrData[(w0 + 1) % 16], 32'h4A6C);
    @(negedge clk);
    check(!done && !busy, {tag, " R9 done one cycle"}, {30'd0, done, busy}, 0);
    copPresent = 1'b1;
  endtask

  task automatic idleCheck(input string tag);
    int o0;
    o0 = opCnt;
    pulseReq(1'b1, 1'b0);
    check(!busy && !memReq, {tag, " no sequence"}, {30'd0, busy, memReq}, 0);
    @(negedge clk); @(negedge clk);
    check(opCnt == o0 && !done, {tag, " no access"}, opCnt - o0, 0);
  endtask

  task automatic resetCase();
    check(!busy && !done && !memReq && !usageErr, "R9 reset state",
          {28'd0, busy, done, memReq, usageErr}, 0);
  endtask

  task automatic absentCase();
    trapCase("R1 absent w0", 1'b0, 0, 32'hA5A5_5A7F, 32'h3E0);
    trapCase("R1 R8 absent w2", 1'b0, 2, 32'h0F0F_00E3, 32'h3E0);
  endtask

  task automatic errorCase();
    @(negedge clk); copErrIn = 1'b1;
    @(negedge clk); copErrIn = 1'b0;
    @(negedge clk);
    check(!busy && !memReq, "R2 fault alone idle", {30'd0, busy, memReq}, 0);
    trapCase("R2 error trap", 1'b1, 1, 32'h1234_56A0, 32'h3DC);
    idleCheck("R2 latch cleared");
  endtask

  task automatic priorityCase();
    @(negedge clk); copErrIn = 1'b1;
    @(negedge clk); copErrIn = 1'b0;
    trapCase("R3 absent first", 1'b0, 0, 32'h8000_0021, 32'h3E0);
    trapCase("R3 fault kept", 1'b1, 0, 32'h8000_0021, 32'h3DC);
  endtask

  task automatic noFaultCase();
    idleCheck("R10 present no fault");
  endtask

  task automatic roundTripCase();
    int n;
    trapCase("R6 pre-trap", 1'b0, 1, 32'hDEAD_BE3F, 32'h3E0);
    memWait = 1; r15In = 32'h1F8; psIn = 32'hDEAD_BE1F;
    pulseReq(1'b0, 1'b1);
    waitDone(n);
    check(n == 5, "R6 R9 return done cycle", n, 5);
    check(pcWe && pcOut == 32'h4A6C, "R6 PC popped", pcOut, 32'h4A6C);
    check(psWe && psOut == 32'hDEAD_BE3F, "R6 PS popped", psOut, 32'hDEAD_BE3F);
    check(r15We && !sspWe && r15Out == 32'h200, "R6 r15 advanced", r15Out, 32'h200);
    mem[32'h100 >> 2] = 32'h0000_7770; mem[32'h104 >> 2] = 32'h5555_0005;
    memWait = 0; r15In = 32'h100; psIn = 32'h0;
    pulseReq(1'b0, 1'b1);
    waitDone(n);
    check(n == 3, "R6 R9 return w0 cycle", n, 3);
    check(pcOut == 32'h7770 && psOut == 32'h5555_0005, "R6 direct pop", psOut, 32'h5555_0005);
    check(r15Out == 32'h108, "R6 r15 plus 8", r15Out, 32'h108);
  endtask

  task automatic usageCase();
    int o0;
    o0 = opCnt; r15In = 32'h100; psIn = 32'h0000_0020;
    pulseReq(1'b0, 1'b1);
    check(usageErr && !busy, "R7 usage error raised", {30'd0, usageErr, busy}, 2);
    @(negedge clk);
    check(!usageErr && !busy && !done, "R7 one cycle, no sequence",
          {29'd0, usageErr, busy, done}, 0);
    check(opCnt == o0, "R7 no memory access", opCnt - o0, 0);
  endtask

  task automatic busyIgnoreCase();
    int n, w0;
    memWait = 1; copPresent = 1'b0; sspIn = 32'h200; psIn = 32'h0; tbrIn = 32'h1000;
    w0 = wrCnt;
    pulseReq(1'b1, 1'b0);
    copInstr = 1'b1; retiReq = 1'b1;
    @(negedge clk);
    copInstr = 1'b0; retiReq = 1'b0;
    waitDone(n);
    @(negedge clk); @(negedge clk);
    check(!busy && !usageErr, "R10 no second sequence", {30'd0, busy, usageErr}, 0);
    check(wrCnt - w0 == 2, "R10 only two writes", wrCnt - w0, 2);
    copPresent = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    resetCase();
    absentCase();
    errorCase();
    priorityCase();
    noFaultCase();
    roundTripCase();
    usageCase();
    busyIgnoreCase();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule